// File: doc/BRIEF.md
# Speculative Branch Predicate Queue

The block is a circular queue of one-bit branch predicates placed between the execute stage and the fetch unit. A push instruction reserves the tail entry in program order and gets back that entry's index. When the push executes later, it writes its predicate to that index, so entries fill out of order. A pop at fetch reads the head entry. If the entry has been written, the pop is a hit and fetch steers the branch with the stored predicate. If not, it is a miss and fetch must stall or predict.

The queue keeps three sets of pointers: speculative head and tail pointers that fetch moves, snapshots of them in a small file of checkpoint slots for recovery after a misprediction, and committed head and tail pointers that move only at retirement. On a full flush the speculative state is rebuilt from the committed pointers. An occupancy length counts entries from reservation until the matching pop retires, and it blocks reservations while the queue is full. The depth must be a power of two. Pointers carry one extra wrap bit, so the queue can tell full from empty and indices wrap modulo the depth.

Top module: `pred_queue`

## Requirements
- R1: After reset: length 0, push grant high, reserved index 0, pop hit low.
- R2: An accepted push reserves the entry at the current tail index, which then advances by one modulo DEPTH, and the length rises by one.
- R3: While the length equals DEPTH, push grant is low and a push request changes neither the tail index nor the length.
- R4: A predicate write at execute sets the entry named by its index, in any order. A pop of a written entry is a hit and returns the stored predicate. This includes entries reached after the index wraps.
- R5: The pop result is a miss, with the predicate output 0, when the head entry has not been written since it was reserved or when no reserved entry remains unpopped.
- R6: Each pop request advances the speculative head by one, so pops read entries in the order they were reserved.
- R7: A save records the speculative head and tail as they stand before that cycle's push or pop, into the chosen slot. A restore loads both pointers from its slot and sets the length to the restored tail minus the committed head.
- R8: Push and pop retire pulses advance the committed tail and head. A flush sets the speculative head and tail to the committed ones and the length to their difference. Flush overrides restore, and either one cancels that cycle's push and pop.
- R9: The length drops by one on a pop retire. A push reservation and a pop retire in the same cycle leave it unchanged. Speculative pops alone do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_req_i | input | 1 | Reserve tail entry |
| push_gnt_o | output | 1 | Queue not full, reservation accepted |
| push_idx_o | output | $clog2(DEPTH) | Index of the entry a push reserves this cycle |
| wr_vld_i | input | 1 | Predicate write from execute |
| wr_idx_i | input | $clog2(DEPTH) | Entry index to write |
| wr_pred_i | input | 1 | Predicate value |
| pop_req_i | input | 1 | Consume head entry at fetch |
| pop_hit_o | output | 1 | Head entry written and available |
| pop_pred_o | output | 1 | Head predicate, 0 on miss |
| push_ret_i | input | 1 | A push retired |
| pop_ret_i | input | 1 | A pop retired |
| ckpt_save_i | input | 1 | Snapshot speculative pointers |
| ckpt_save_id_i | input | $clog2(NUM_CKPT) | Slot to write |
| rcv_i | input | 1 | Restore pointers from a checkpoint |
| rcv_id_i | input | $clog2(NUM_CKPT) | Slot to read |
| flush_i | input | 1 | Rebuild speculative state from committed |
| len_o | output | $clog2(DEPTH)+1 | Occupancy length |

## Verification
A wrong speculative head shows up on the next cycle as a wrong predicate or a wrong hit flag at the pop port. A wrong tail shows up at once on the reserved index output. A stale written bit turns a required miss into a hit on the first pop that reaches that entry. A checkpoint or committed pointer error stays hidden until a restore or flush, and then appears in the cycle after it as a wrong head predicate, index or length. The sweeps therefore read every entry in order, save into and restore from several slots, and check the length after every class of update.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    PQ_STEP   = 2'd0,
    PQ_CKPT   = 2'd1,
    PQ_COMMIT = 2'd2
  } pq_src_e;
endpackage

// File: rtl/pq_entries.sv
module pq_entries #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsv_i,
  input  logic [IDX_W-1:0] rsv_idx_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_pred_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_written_o,
  output logic             rd_pred_o
);
  logic [DEPTH-1:0] written_q;
  logic [DEPTH-1:0] pred_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic rsv_hit, wr_hit;
    assign rsv_hit = rsv_i && (rsv_idx_i == IDX_W'(e));
    assign wr_hit  = wr_i  && (wr_idx_i  == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        written_q[e] <= 1'b0;
        pred_q[e]    <= 1'b0;
      end else if (rsv_hit) begin
        written_q[e] <= 1'b0;
      end else if (wr_hit) begin
        written_q[e] <= 1'b1;
        pred_q[e]    <= wr_pred_i;
      end
    end
  end

  assign rd_written_o = written_q[rd_idx_i];
  assign rd_pred_o    = pred_q[rd_idx_i];

  // writing an entry while it is being reserved is illegal
  AST_WR_NOT_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rsv_i) |-> (wr_idx_i != rsv_idx_i)); // R4
endmodule

// File: rtl/pq_ckpt_file.sv
module pq_ckpt_file #(
  parameter int NUM_CKPT = 8,
  parameter int PW = 8,
  localparam int CID_W = $clog2(NUM_CKPT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic [CID_W-1:0] save_id_i,
  input  logic [PW-1:0]    save_head_i,
  input  logic [PW-1:0]    save_tail_i,
  input  logic [CID_W-1:0] rd_id_i,
  output logic [PW-1:0]    rd_head_o,
  output logic [PW-1:0]    rd_tail_o
);
  logic [PW-1:0] head_q [NUM_CKPT];
  logic [PW-1:0] tail_q [NUM_CKPT];

  for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        head_q[s] <= '0;
        tail_q[s] <= '0;
      end else if (save_i && (save_id_i == CID_W'(s))) begin
        head_q[s] <= save_head_i;
        tail_q[s] <= save_tail_i;
      end
    end
  end

  assign rd_head_o = head_q[rd_id_i];
  assign rd_tail_o = tail_q[rd_id_i];
endmodule

// File: rtl/pq_commit.sv
module pq_commit #(
  parameter int DEPTH = 128,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_ret_i,
  input  logic          pop_ret_i,
  output logic [PW-1:0] chead_o,
  output logic [PW-1:0] chead_nxt_o,
  output logic [PW-1:0] ctail_nxt_o
);
  logic [PW-1:0] chead_q, ctail_q;

  assign chead_nxt_o = chead_q + PW'(pop_ret_i);
  assign ctail_nxt_o = ctail_q + PW'(push_ret_i);
  assign chead_o     = chead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chead_q <= '0;
      ctail_q <= '0;
    end else begin
      chead_q <= chead_nxt_o;
      ctail_q <= ctail_nxt_o;
    end
  end

  AST_COMMIT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctail_q - chead_q) <= PW'(DEPTH)); // R8
endmodule

// File: rtl/pred_queue.sv
module pred_queue
  import pq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int NUM_CKPT = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PW = IDX_W + 1,
  localparam int CID_W = $clog2(NUM_CKPT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_req_i,
  output logic             push_gnt_o,
  output logic [IDX_W-1:0] push_idx_o,
  input  logic             wr_vld_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_pred_i,
  input  logic             pop_req_i,
  output logic             pop_hit_o,
  output logic             pop_pred_o,
  input  logic             push_ret_i,
  input  logic             pop_ret_i,
  input  logic             ckpt_save_i,
  input  logic [CID_W-1:0] ckpt_save_id_i,
  input  logic             rcv_i,
  input  logic [CID_W-1:0] rcv_id_i,
  input  logic             flush_i,
  output logic [PW-1:0]    len_o
);
  logic [PW-1:0] head_q, tail_q, len_q;
  logic [PW-1:0] head_d, tail_d, len_d;
  logic [PW-1:0] avail;
  logic [PW-1:0] ck_head, ck_tail;
  logic [PW-1:0] chead, chead_nxt, ctail_nxt;
  logic          push_go, pop_go, rd_written, rd_pred;
  pq_src_e       src;

  assign avail      = tail_q - head_q;
  assign push_gnt_o = (len_q != PW'(DEPTH));
  assign push_go    = push_req_i && push_gnt_o && !flush_i && !rcv_i;
  assign pop_go     = pop_req_i && (avail != '0) && !flush_i && !rcv_i;
  assign push_idx_o = tail_q[IDX_W-1:0];
  assign len_o      = len_q;

  pq_entries #(.DEPTH(DEPTH)) i_entries (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rsv_i       (push_go),
    .rsv_idx_i   (tail_q[IDX_W-1:0]),
    .wr_i        (wr_vld_i),
    .wr_idx_i    (wr_idx_i),
    .wr_pred_i   (wr_pred_i),
    .rd_idx_i    (head_q[IDX_W-1:0]),
    .rd_written_o(rd_written),
    .rd_pred_o   (rd_pred)
  );

  pq_ckpt_file #(.NUM_CKPT(NUM_CKPT), .PW(PW)) i_ckpt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_i     (ckpt_save_i),
    .save_id_i  (ckpt_save_id_i),
    .save_head_i(head_q),
    .save_tail_i(tail_q),
    .rd_id_i    (rcv_id_i),
    .rd_head_o  (ck_head),
    .rd_tail_o  (ck_tail)
  );

  pq_commit #(.DEPTH(DEPTH)) i_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_ret_i (push_ret_i),
    .pop_ret_i  (pop_ret_i),
    .chead_o    (chead),
    .chead_nxt_o(chead_nxt),
    .ctail_nxt_o(ctail_nxt)
  );

  assign pop_hit_o  = (avail != '0) && rd_written;
  assign pop_pred_o = pop_hit_o && rd_pred;

  always_comb begin
    if (flush_i)    src = PQ_COMMIT;
    else if (rcv_i) src = PQ_CKPT;
    else            src = PQ_STEP;
  end

  always_comb begin
    unique case (src)
      PQ_COMMIT: begin
        head_d = chead_nxt;
        tail_d = ctail_nxt;
        len_d  = ctail_nxt - chead_nxt;
      end
      PQ_CKPT: begin
        head_d = ck_head;
        tail_d = ck_tail;
        len_d  = ck_tail - chead_nxt;  // retired pops since the snapshot are accounted
      end
      default: begin
        head_d = head_q + PW'(pop_go);
        tail_d = tail_q + PW'(push_go);
        len_d  = len_q + PW'(push_go) - PW'(pop_ret_i);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      len_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      len_q  <= len_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= PW'(DEPTH)); // R3
  AST_LEN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q == (tail_q - chead)); // R9
  AST_SPEC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail <= PW'(DEPTH)); // R6
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_gnt_o && !flush_i && !rcv_i) |=> (tail_q == $past(tail_q))); // R3
endmodule

// File: tb/test_pred_queue.sv
`timescale 1ns/1ps
module test_pred_queue;
  localparam int D = 8;
  localparam int C = 4;
  localparam int IW = $clog2(D);
  localparam int PW = IW + 1;
  localparam int CW = $clog2(C);

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_req = 0, wr_vld = 0, wr_pred = 0, pop_req = 0;
  logic push_ret = 0, pop_ret = 0, ck_save = 0, rcv = 0, flush = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [CW-1:0] ck_id = '0, rcv_id = '0;
  logic push_gnt, pop_hit, pop_pred;
  logic [IW-1:0] push_idx;
  logic [PW-1:0] len;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pred_queue #(.DEPTH(D), .NUM_CKPT(C)) i_pred_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .push_req_i(push_req), .push_gnt_o(push_gnt), .push_idx_o(push_idx),
    .wr_vld_i(wr_vld), .wr_idx_i(wr_idx), .wr_pred_i(wr_pred),
    .pop_req_i(pop_req), .pop_hit_o(pop_hit), .pop_pred_o(pop_pred),
    .push_ret_i(push_ret), .pop_ret_i(pop_ret),
    .ckpt_save_i(ck_save), .ckpt_save_id_i(ck_id),
    .rcv_i(rcv), .rcv_id_i(rcv_id), .flush_i(flush), .len_o(len)
  );

  function automatic logic fp(int i);
    return logic'((i & 1) ^ ((i >> 1) & 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    push_req = 0; wr_vld = 0; pop_req = 0; push_ret = 0; pop_ret = 0;
    ck_save = 0; rcv = 0; flush = 0;
  endtask

  task automatic wr(int idx, logic p);
    wr_vld = 1; wr_idx = IW'(idx); wr_pred = p; tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1;
    @(posedge clk); #1;
    chk("R1 len", int'(len), 0);
    chk("R1 gnt", int'(push_gnt), 1);
    chk("R1 idx", int'(push_idx), 0);
    chk("R1 hit", int'(pop_hit), 0);

    for (int i = 0; i < D; i++) begin
      chk("R2 idx", int'(push_idx), i);
      push_req = 1; tick();
      chk("R2 len", int'(len), i + 1);
    end
    chk("R3 gnt full", int'(push_gnt), 0);
    push_req = 1; tick();
    chk("R3 len held", int'(len), D);
    chk("R3 idx held", int'(push_idx), 0);

    for (int i = 0; i < D; i++) begin push_ret = 1; tick(); end
    chk("R9 push retire keeps len", int'(len), D);

    chk("R5 unwritten miss", int'(pop_hit), 0);
    for (int i = D - 1; i >= 1; i--) wr(i, fp(i));
    chk("R5 head still miss", int'(pop_hit), 0);
    chk("R5 pred zero on miss", int'(pop_pred), 0);
    wr(0, fp(0));
    chk("R4 hit", int'(pop_hit), 1);

    for (int k = 0; k < D; k++) begin
      chk("R6 hit", int'(pop_hit), 1);
      chk("R6 pred order", int'(pop_pred), int'(fp(k)));
      if (k < C) begin ck_save = 1; ck_id = CW'(k); end
      pop_req = 1; tick();
    end
    chk("R5 empty miss", int'(pop_hit), 0);
    chk("R9 pops keep len", int'(len), D);

    for (int s = C - 1; s >= 0; s--) begin
      rcv = 1; rcv_id = CW'(s); tick();
      chk("R7 restored pred", int'(pop_pred), int'(fp(s)));
      chk("R7 restored hit", int'(pop_hit), 1);
      chk("R7 restored len", int'(len), D);
    end
    // head now 0; pop three and retire them
    for (int i = 0; i < 3; i++) begin pop_req = 1; tick(); end
    chk("R6 pred after pops", int'(pop_pred), int'(fp(3)));
    for (int i = 0; i < 3; i++) begin pop_ret = 1; tick(); end
    chk("R9 len after retire", int'(len), D - 3);
    chk("R3 gnt back", int'(push_gnt), 1);

    chk("R2 wrapped idx", int'(push_idx), 0);
    push_req = 1; tick();
    chk("R2 len inc", int'(len), D - 2);
    chk("R2 idx next", int'(push_idx), 1);
    push_req = 1; pop_ret = 1; tick();
    chk("R9 simultaneous", int'(len), D - 2);
    chk("R2 idx after", int'(push_idx), 2);

    // committed: head 4, tail 8
    flush = 1; tick();
    chk("R8 flush len", int'(len), 4);
    chk("R8 flush idx", int'(push_idx), 0);
    chk("R8 flush pred", int'(pop_pred), int'(fp(4)));
    chk("R8 flush hit", int'(pop_hit), 1);

    // flush overrides restore, push cancelled
    flush = 1; rcv = 1; rcv_id = CW'(0); push_req = 1; tick();
    chk("R8 flush priority len", int'(len), 4);
    chk("R8 flush priority idx", int'(push_idx), 0);

    push_req = 1; tick();
    chk("R2 len after flush push", int'(len), 5);
    for (int k = 4; k < D; k++) begin
      chk("R6 post flush pred", int'(pop_pred), int'(fp(k)));
      pop_req = 1; tick();
    end
    chk("R5 wrapped unwritten miss", int'(pop_hit), 0);
    wr(0, 1'b1);
    chk("R4 wrapped hit", int'(pop_hit), 1);
    chk("R4 wrapped pred", int'(pop_pred), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule